// File: doc/BRIEF.md
# Segmented-Scan Buffer Bank Power Sequencer

This block schedules the power states of the two context stores used by a segmented wavelet engine. In that engine each image row is processed in segments of `SEG_LEN` elements. Before a segment starts, the row's four-value lifting context is fetched from a row store. When the segment ends, the context is stored back. A column store with `SEG_LEN` slots is touched once for every element. Both stores are split into banks. A bank may hold its data in a low-leakage retention state and only needs full power in the cycles when it is actually read or written.

After a `start` pulse the sequencer walks a whole tile by itself. The tile has `SEGS` segment passes. Each pass covers all `ROWS` rows in order, and each row segment covers `SEG_LEN` elements, one element per cycle. Because the access pattern follows entirely from the scan position, the sequencer knows one cycle ahead which bank will be touched. It raises that bank's wake request early enough that the access never waits. When a run of accesses ends it lowers the bank again and marks this with a sleep request.

The outputs are per-bank power levels, wake and sleep pulses, and read/write/access strobes with bank and location indices. These outputs feed the memory macros' power pins and ports directly.

Top module: `zscan_bank_pwr_ctl`

## Requirements
- R1: While reset is asserted, and in the first idle cycle after it, `busy`, `done`, all strobes and every bank power, wake and sleep bit are 0.
- R2: A `start` pulse seen while idle raises `row_wake[0]` and `col_wake[0]` in that same cycle. In the next cycle `busy` is 1, `row_rd` is 1 and `col_addr` is 0.
- R3: While busy, `col_acc` is 1 in every cycle. `col_addr` counts 0..SEG_LEN-1 and then wraps. `col_bank` equals `col_addr / (SEG_LEN/CB_BANKS)`.
- R4: `row_rd` is 1 at element 0 of each row segment and `row_wr` is 1 at element SEG_LEN-1. `row_bank` is row / (ROWS/RB_BANKS) and `row_addr` is row mod (ROWS/RB_BANKS). Rows advance 0..ROWS-1 inside a segment pass.
- R5: For each buffer, bit k of the power vector (`row_on`, `col_on`) is 1 exactly in the cycles where bank k is accessed. Wake bit k pulses in the cycle before such a cycle whenever bank k is not already powered.
- R6: Sleep bit k pulses in the first cycle after a run of consecutive accesses to bank k. In that cycle the bank's power bit is already 0.
- R7: At most one bit of `row_on` and at most one bit of `col_on` is 1 in any cycle.
- R8: Within a row segment the row store stays unpowered for the SEG_LEN-2 elements between the fetch and the write-back. When consecutive rows share a bank, the write-back of one row and the fetch of the next use a single wake.
- R9: Over one tile each row bank is woken SEGS*(ROWS/RB_BANKS+1) times and each column bank ROWS*SEGS times.
- R10: A `start` pulse while busy has no effect on any output.
- R11: `busy` stays high for exactly ROWS*SEGS*SEG_LEN cycles. `done` pulses once, in the cycle after the last element, with `busy` already 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a tile walk (ignored while busy) |
| busy | output | 1 | An element is processed this cycle |
| done | output | 1 | One-cycle pulse after the last element of a tile |
| row_rd | output | 1 | Row-store context fetch strobe |
| row_wr | output | 1 | Row-store context write-back strobe |
| row_bank | output | idx_w(RB_BANKS) | Row-store bank holding the current row |
| row_addr | output | idx_w(ROWS/RB_BANKS) | Location of the current row inside its bank |
| row_on | output | RB_BANKS | Row-store bank power levels (1 = full power) |
| row_wake | output | RB_BANKS | Row-store bank wake requests |
| row_sleep | output | RB_BANKS | Row-store bank sleep requests |
| col_acc | output | 1 | Column-store access strobe |
| col_addr | output | idx_w(SEG_LEN) | Column-store slot (element position in segment) |
| col_bank | output | idx_w(CB_BANKS) | Column-store bank of the slot |
| col_on | output | CB_BANKS | Column-store bank power levels |
| col_wake | output | CB_BANKS | Column-store bank wake requests |
| col_sleep | output | CB_BANKS | Column-store bank sleep requests |

## Verification
A corrupted position or row counter shows in the very next cycle as a wrong `col_addr`, `row_bank` or misplaced `row_rd`/`row_wr`. A wrong lookahead shows as a strobe whose bank power bit is low, or as a wake pulse that is not followed by power. Both appear at the port in the cycle of the access and are compared every cycle against an independent position model. Slower faults, such as a bank that is not released or is woken too often, surface as a second power bit or as a wrong per-bank wake total at the end of the tile.

// File: rtl/zsb_pkg.sv
package zsb_pkg;

   // Width of an index able to hold values 0..n-1 (never below one bit).
   function automatic int unsigned idx_w(input int unsigned n);
      return (n < 2) ? 1 : $clog2(n);
   endfunction

   function automatic bit is_pow2(input int unsigned n);
      return (n != 0) && ((n & (n - 1)) == 0);
   endfunction

endpackage

// File: rtl/zsb_scan_seq.sv
module zsb_scan_seq
   import zsb_pkg::*;
#(
   parameter int unsigned ROWS    = 32,
   parameter int unsigned SEG_LEN = 64,
   parameter int unsigned SEGS    = 2,
   localparam int unsigned PW = idx_w(SEG_LEN),
   localparam int unsigned RW = idx_w(ROWS)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   output logic          busy,
   output logic          done,
   output logic [PW-1:0] pos,
   output logic [RW-1:0] row,
   output logic          nxt_busy,
   output logic [PW-1:0] nxt_pos,
   output logic [RW-1:0] nxt_row
);
   localparam int unsigned SW = idx_w(SEGS);
   localparam logic [PW-1:0] LAST_POS = PW'(SEG_LEN - 1);
   localparam logic [RW-1:0] LAST_ROW = RW'(ROWS - 1);
   localparam logic [SW-1:0] LAST_SEG = SW'(SEGS - 1);

   logic [SW-1:0] seg, nxt_seg;
   logic          tile_end;

   // Next scan position; also serves as the one-cycle lookahead.
   always_comb begin
      nxt_busy = busy;
      nxt_pos  = pos;
      nxt_row  = row;
      nxt_seg  = seg;
      tile_end = 1'b0;
      if (!busy) begin
         if (start) begin
            nxt_busy = 1'b1;
            nxt_pos  = '0;
            nxt_row  = '0;
            nxt_seg  = '0;
         end
      end else if (pos != LAST_POS) begin
         nxt_pos = pos + 1'b1;
      end else begin
         nxt_pos = '0;
         if (row != LAST_ROW) begin
            nxt_row = row + 1'b1;
         end else begin
            nxt_row = '0;
            if (seg != LAST_SEG) begin
               nxt_seg = seg + 1'b1;
            end else begin
               nxt_seg  = '0;
               nxt_busy = 1'b0;
               tile_end = 1'b1;
            end
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy <= 1'b0;
         pos  <= '0;
         row  <= '0;
         seg  <= '0;
         done <= 1'b0;
      end else begin
         busy <= nxt_busy;
         pos  <= nxt_pos;
         row  <= nxt_row;
         seg  <= nxt_seg;
         done <= tile_end;
      end
   end

endmodule

// File: rtl/zsb_bank_index.sv
module zsb_bank_index
   import zsb_pkg::*;
#(
   parameter int unsigned ITEMS  = 64,
   parameter int unsigned NBANKS = 4,
   localparam int unsigned PER = ITEMS / NBANKS,
   localparam int unsigned IW  = idx_w(ITEMS),
   localparam int unsigned BW  = idx_w(NBANKS),
   localparam int unsigned OW  = idx_w(PER)
) (
   input  logic [IW-1:0] item,
   output logic [BW-1:0] bank,
   output logic [OW-1:0] offset
);
   generate
      if (NBANKS == 1) begin : g_single
         assign bank   = '0;
         assign offset = OW'(item);
      end else if (is_pow2(PER)) begin : g_shift
         localparam int unsigned SH = $clog2(PER);
         localparam logic [IW-1:0] MASK = IW'(PER - 1);
         assign bank   = BW'(item >> SH);
         assign offset = OW'(item & MASK);
      end else begin : g_divide
         assign bank   = BW'(item / IW'(PER));
         assign offset = OW'(item % IW'(PER));
      end
   endgenerate

endmodule

// File: rtl/zsb_bank_power.sv
module zsb_bank_power
   import zsb_pkg::*;
#(
   parameter int unsigned NBANKS = 4,
   localparam int unsigned BW = idx_w(NBANKS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              nxt_req,
   input  logic [BW-1:0]     nxt_bank,
   output logic [NBANKS-1:0] on,
   output logic [NBANKS-1:0] wake,
   output logic [NBANKS-1:0] sleep
);
   for (genvar k = 0; k < NBANKS; k++) begin : g_bank
      logic hit_nxt;
      assign hit_nxt = nxt_req && (nxt_bank == BW'(k));
      // Request power one cycle ahead unless it is already held.
      assign wake[k] = hit_nxt && !on[k];

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            on[k]    <= 1'b0;
            sleep[k] <= 1'b0;
         end else begin
            on[k]    <= hit_nxt;
            sleep[k] <= on[k] && !hit_nxt;
         end
      end
   end

endmodule

// File: rtl/zscan_bank_pwr_ctl.sv
module zscan_bank_pwr_ctl
   import zsb_pkg::*;
#(
   parameter int unsigned ROWS     = 32,
   parameter int unsigned SEG_LEN  = 64,
   parameter int unsigned SEGS     = 2,
   parameter int unsigned RB_BANKS = 8,
   parameter int unsigned CB_BANKS = 4,
   localparam int unsigned PW  = idx_w(SEG_LEN),
   localparam int unsigned RW  = idx_w(ROWS),
   localparam int unsigned RBW = idx_w(RB_BANKS),
   localparam int unsigned RAW = idx_w(ROWS / RB_BANKS),
   localparam int unsigned CBW = idx_w(CB_BANKS),
   localparam int unsigned CAW = idx_w(SEG_LEN / CB_BANKS)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                start,
   output logic                busy,
   output logic                done,
   output logic                row_rd,
   output logic                row_wr,
   output logic [RBW-1:0]      row_bank,
   output logic [RAW-1:0]      row_addr,
   output logic [RB_BANKS-1:0] row_on,
   output logic [RB_BANKS-1:0] row_wake,
   output logic [RB_BANKS-1:0] row_sleep,
   output logic                col_acc,
   output logic [PW-1:0]       col_addr,
   output logic [CBW-1:0]      col_bank,
   output logic [CB_BANKS-1:0] col_on,
   output logic [CB_BANKS-1:0] col_wake,
   output logic [CB_BANKS-1:0] col_sleep
);
   localparam logic [PW-1:0] LAST_POS = PW'(SEG_LEN - 1);

   // Elaboration-time parameter checks.
   generate
      if (SEG_LEN < 4) begin : g_bad_seg
         $error("SEG_LEN must be at least 4");
      end
      if (CB_BANKS == 0 || (SEG_LEN % CB_BANKS) != 0) begin : g_bad_cb
         $error("SEG_LEN must be a multiple of CB_BANKS");
      end
      if (RB_BANKS == 0 || (ROWS % RB_BANKS) != 0) begin : g_bad_rb
         $error("ROWS must be a multiple of RB_BANKS");
      end
      if (SEGS == 0) begin : g_bad_segs
         $error("SEGS must be nonzero");
      end
   endgenerate

   logic          nxt_busy;
   logic [PW-1:0] pos, nxt_pos;
   logic [RW-1:0] row, nxt_row;

   zsb_scan_seq #(.ROWS(ROWS), .SEG_LEN(SEG_LEN), .SEGS(SEGS)) i_scan (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (start),
      .busy     (busy),
      .done     (done),
      .pos      (pos),
      .row      (row),
      .nxt_busy (nxt_busy),
      .nxt_pos  (nxt_pos),
      .nxt_row  (nxt_row)
   );

   // Bank selection for the current and the next cycle.
   logic [RBW-1:0] nxt_row_bank;
   logic [RAW-1:0] nxt_row_off;
   logic [CBW-1:0] nxt_col_bank;
   logic [CAW-1:0] nxt_col_off, col_off;

   zsb_bank_index #(.ITEMS(ROWS), .NBANKS(RB_BANKS)) i_row_idx_now (
      .item (row), .bank (row_bank), .offset (row_addr)
   );
   zsb_bank_index #(.ITEMS(ROWS), .NBANKS(RB_BANKS)) i_row_idx_nxt (
      .item (nxt_row), .bank (nxt_row_bank), .offset (nxt_row_off)
   );
   zsb_bank_index #(.ITEMS(SEG_LEN), .NBANKS(CB_BANKS)) i_col_idx_now (
      .item (pos), .bank (col_bank), .offset (col_off)
   );
   zsb_bank_index #(.ITEMS(SEG_LEN), .NBANKS(CB_BANKS)) i_col_idx_nxt (
      .item (nxt_pos), .bank (nxt_col_bank), .offset (nxt_col_off)
   );

   // Row store touched at the first and last element of a segment.
   logic row_req_nxt;
   assign row_req_nxt = nxt_busy && ((nxt_pos == '0) || (nxt_pos == LAST_POS));
   assign row_rd      = busy && (pos == '0);
   assign row_wr      = busy && (pos == LAST_POS);

   assign col_acc  = busy;
   assign col_addr = pos;

   zsb_bank_power #(.NBANKS(RB_BANKS)) i_row_pwr (
      .clk      (clk),
      .rst_n    (rst_n),
      .nxt_req  (row_req_nxt),
      .nxt_bank (nxt_row_bank),
      .on       (row_on),
      .wake     (row_wake),
      .sleep    (row_sleep)
   );

   zsb_bank_power #(.NBANKS(CB_BANKS)) i_col_pwr (
      .clk      (clk),
      .rst_n    (rst_n),
      .nxt_req  (nxt_busy),
      .nxt_bank (nxt_col_bank),
      .on       (col_on),
      .wake     (col_wake),
      .sleep    (col_sleep)
   );

   // Offsets inside a column bank are implied by col_addr; keep them for clarity.
   logic unused_offsets;
   assign unused_offsets = ^{nxt_row_off, nxt_col_off, col_off};

endmodule

// File: rtl/zscan_bank_pwr_ctl_chk.sv
module zscan_bank_pwr_ctl_chk #(
   parameter int unsigned RB_BANKS = 8,
   parameter int unsigned CB_BANKS = 4,
   parameter int unsigned RBW      = 3,
   parameter int unsigned CBW      = 2,
   parameter int unsigned PW       = 6
) (
   input logic                clk,
   input logic                rst_n,
   input logic                start,
   input logic                busy,
   input logic                done,
   input logic                row_rd,
   input logic                row_wr,
   input logic [RBW-1:0]      row_bank,
   input logic [RB_BANKS-1:0] row_on,
   input logic [RB_BANKS-1:0] row_wake,
   input logic [RB_BANKS-1:0] row_sleep,
   input logic                col_acc,
   input logic [PW-1:0]       col_addr,
   input logic [CBW-1:0]      col_bank,
   input logic [CB_BANKS-1:0] col_on,
   input logic [CB_BANKS-1:0] col_wake,
   input logic [CB_BANKS-1:0] col_sleep
);
   // R7
   row_one_awake_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(row_on));
   // R7
   col_one_awake_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(col_on));
   // R5
   row_wake_lead_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (row_wake != '0) |=> ((row_on & $past(row_wake)) == $past(row_wake)));
   // R5
   col_wake_lead_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (col_wake != '0) |=> ((col_on & $past(col_wake)) == $past(col_wake)));
   // R6
   row_sleep_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (row_sleep != '0) |-> ((($past(row_on) & row_sleep) == row_sleep) && ((row_on & row_sleep) == '0)));
   // R6
   col_sleep_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (col_sleep != '0) |-> ((($past(col_on) & col_sleep) == col_sleep) && ((col_on & col_sleep) == '0)));
   // R4
   row_strobe_power_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (row_rd || row_wr) |-> (row_on == (RB_BANKS'(1) << row_bank)));
   // R3
   col_strobe_power_chk: assert property (@(posedge clk) disable iff (!rst_n)
      col_acc |-> (col_on == (CB_BANKS'(1) << col_bank)));
   // R8
   row_mid_retain_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !row_rd && !row_wr) |-> (row_on == '0));
   // R11
   done_after_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (!busy && $past(busy)));
   // R2
   start_launch_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy) |=> (busy && row_rd && (col_addr == '0)));

endmodule

bind zscan_bank_pwr_ctl zscan_bank_pwr_ctl_chk #(
   .RB_BANKS (RB_BANKS), .CB_BANKS (CB_BANKS), .RBW (RBW), .CBW (CBW), .PW (PW)
) i_zscan_bank_pwr_ctl_chk (
   .clk (clk), .rst_n (rst_n), .start (start), .busy (busy), .done (done),
   .row_rd (row_rd), .row_wr (row_wr), .row_bank (row_bank), .row_on (row_on),
   .row_wake (row_wake), .row_sleep (row_sleep), .col_acc (col_acc),
   .col_addr (col_addr), .col_bank (col_bank), .col_on (col_on),
   .col_wake (col_wake), .col_sleep (col_sleep)
);

// File: tb/test_zscan_bank_pwr_ctl.sv
module test_zscan_bank_pwr_ctl;
   localparam int ROWS = 32, R = 64, SEGS = 2, RB = 8, CB = 4;
   localparam int RPB = ROWS / RB, CPB = R / CB, N = ROWS * SEGS * R;

   logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
   logic busy, done, row_rd, row_wr, col_acc;
   logic [2:0] row_bank;
   logic [1:0] row_addr;
   logic [RB-1:0] row_on, row_wake, row_sleep;
   logic [5:0] col_addr;
   logic [1:0] col_bank;
   logic [CB-1:0] col_on, col_wake, col_sleep;

   int checks = 0, errors = 0, cycles = 0;
   int rwake_cnt [RB];
   int cwake_cnt [CB];

   always #10 clk = ~clk;

   zscan_bank_pwr_ctl #(.ROWS(ROWS), .SEG_LEN(R), .SEGS(SEGS), .RB_BANKS(RB), .CB_BANKS(CB))
   i_zscan_bank_pwr_ctl (
      .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
      .row_rd(row_rd), .row_wr(row_wr), .row_bank(row_bank), .row_addr(row_addr),
      .row_on(row_on), .row_wake(row_wake), .row_sleep(row_sleep),
      .col_acc(col_acc), .col_addr(col_addr), .col_bank(col_bank),
      .col_on(col_on), .col_wake(col_wake), .col_sleep(col_sleep)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
      end
   endtask

   task automatic finish_run();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   endtask

   initial begin
      forever begin
         @(posedge clk);
         cycles++;
         if (cycles > 150000) begin
            check(1'b0, "watchdog", cycles, 150000);
            finish_run();
         end
      end
   end

   // Model: row-store access in busy cycle n (n outside 0..N-1 means none).
   function automatic bit racc(input int n, output int bank);
      int p;
      bank = 0;
      if (n < 0 || n >= N) return 1'b0;
      p = n % R;
      bank = ((n / R) % ROWS) / RPB;
      return (p == 0) || (p == R - 1);
   endfunction

   function automatic bit cacc(input int n, output int bank);
      bank = 0;
      if (n < 0 || n >= N) return 1'b0;
      bank = (n % R) / CPB;
      return 1'b1;
   endfunction

   task automatic check_cycle(input int n);
      int b0, bp, bn, p, row;
      bit a0, ap, an;
      logic [RB-1:0] e_ron, e_rwk, e_rsl;
      logic [CB-1:0] e_con, e_cwk, e_csl;
      p   = (n >= 0) ? n % R : 0;
      row = (n >= 0) ? (n / R) % ROWS : 0;
      // R11 busy window and done pulse
      check(busy == (n >= 0 && n < N) && done == (n == N), "R11", {busy, done}, {n >= 0 && n < N, n == N});
      // row buffer power model (R5, R6, R8)
      a0 = racc(n, b0); ap = racc(n - 1, bp); an = racc(n + 1, bn);
      e_ron = a0 ? RB'(1) << b0 : '0;
      e_rwk = (an && !(a0 && b0 == bn)) ? RB'(1) << bn : '0;
      e_rsl = (ap && !(a0 && b0 == bp)) ? RB'(1) << bp : '0;
      check(row_on == e_ron, "R5/R8 row_on", row_on, e_ron);
      check(row_wake == e_rwk, "R5 row_wake", row_wake, e_rwk);
      check(row_sleep == e_rsl, "R6 row_sleep", row_sleep, e_rsl);
      a0 = cacc(n, b0); ap = cacc(n - 1, bp); an = cacc(n + 1, bn);
      e_con = a0 ? CB'(1) << b0 : '0;
      e_cwk = (an && !(a0 && b0 == bn)) ? CB'(1) << bn : '0;
      e_csl = (ap && !(a0 && b0 == bp)) ? CB'(1) << bp : '0;
      check(col_on == e_con, "R5 col_on", col_on, e_con);
      check(col_wake == e_cwk, "R5 col_wake", col_wake, e_cwk);
      check(col_sleep == e_csl, "R6 col_sleep", col_sleep, e_csl);
      // R7 independent one-hot check
      check($countones(row_on) <= 1 && $countones(col_on) <= 1, "R7", {row_on, col_on}, 0);
      if (n >= 0 && n < N) begin
         // R3 column sequencing
         check(col_acc && col_addr == 6'(p) && col_bank == 2'(p / CPB), "R3",
               {col_acc, col_addr, col_bank}, {1'b1, 6'(p), 2'(p / CPB)});
         // R4 row strobes and indices
         check(row_rd == (p == 0) && row_wr == (p == R - 1) && row_bank == 3'(row / RPB)
               && row_addr == 2'(row % RPB), "R4",
               {row_rd, row_wr, row_bank, row_addr},
               {p == 0, p == R - 1, 3'(row / RPB), 2'(row % RPB)});
      end else begin
         check(!col_acc && !row_rd && !row_wr, "R3/R4 idle", {col_acc, row_rd, row_wr}, 0);
      end
      for (int k = 0; k < RB; k++) rwake_cnt[k] += int'(row_wake[k]);
      for (int k = 0; k < CB; k++) cwake_cnt[k] += int'(col_wake[k]);
   endtask

   task automatic check_quiet(input string req);
      check(!busy && !done && !row_rd && !row_wr && !col_acc && row_on == '0 && row_wake == '0
            && row_sleep == '0 && col_on == '0 && col_wake == '0 && col_sleep == '0, req,
            {busy, done, row_on, row_wake, row_sleep, col_on, col_wake, col_sleep}, 0);
   endtask

   // Walk one tile; a second start is pulsed at busy cycle 'inject' (R10); stop early at 'stop_at'.
   task automatic run_tile(input int inject, input int stop_at);
      for (int k = 0; k < RB; k++) rwake_cnt[k] = 0;
      for (int k = 0; k < CB; k++) cwake_cnt[k] = 0;
      @(negedge clk);
      start = 1'b1;
      #2;
      check_cycle(-1); // R2 wake in start cycle
      for (int n = 0; n <= N; n++) begin
         @(negedge clk);
         start = (n == inject);
         #2;
         check_cycle(n);
         if (n == stop_at) begin
            start = 1'b0;
            return;
         end
      end
      start = 1'b0;
   endtask

   task automatic t_reset_state();
      #5;
      check_quiet("R1 during reset");
      @(negedge clk);
      rst_n = 1'b1;
      #2;
      check_quiet("R1 after reset");
   endtask

   task automatic t_full_tile();
      run_tile(-5, N + 1);
      // R9 wake totals per bank
      for (int k = 0; k < RB; k++)
         check(rwake_cnt[k] == SEGS * (RPB + 1), "R9 row wakes", rwake_cnt[k], SEGS * (RPB + 1));
      for (int k = 0; k < CB; k++)
         check(cwake_cnt[k] == ROWS * SEGS, "R9 col wakes", cwake_cnt[k], ROWS * SEGS);
      @(negedge clk);
      #2;
      check_quiet("R11 idle after done");
   endtask

   task automatic t_start_while_busy();
      run_tile(R * RPB + 7, N + 1); // R10: pulse lands mid-segment of a busy tile
      run_tile(R - 2, N + 1);       // R10: pulse lands just before a write-back wake
   endtask

   task automatic t_reset_midrun();
      run_tile(-5, 300);
      @(negedge clk);
      rst_n = 1'b0;
      #2;
      check_quiet("R1 reset mid-tile");
      @(negedge clk);
      rst_n = 1'b1;
      #2;
      check_quiet("R1 idle after mid-tile reset");
      run_tile(-5, N + 1); // R2 restart from element 0 after reset
   endtask

   initial begin
      t_reset_state();
      t_full_tile();
      t_start_while_busy();
      t_reset_midrun();
      repeat (3) @(negedge clk);
      finish_run();
   end

endmodule